// File: doc/BRIEF.md
# Interleaved addressable mode latch

This block is a 32-bit control register whose outputs steer analog routing switches, relays and multiplexers. A host writes it four bits at a time. A 3-bit address chooses one bit position, and that position is the same in each of the four byte lanes. Each bit of a 4-bit data nibble goes to its own lane: nibble bit k lands at output `8*k + addr`. Eight addresses, each carrying four bits, cover all 32 outputs.

Two control inputs together choose how the register changes on each rising clock edge. The clear request (`clr_req`) and the write block (`wr_block`) give four modes:

| `clr_req` | `wr_block` | Mode | Effect |
|---|---|---|---|
| 0 | 0 | write | the four addressed outputs load the nibble; all other outputs hold |
| 0 | 1 | storage | everything holds |
| 1 | 0 | demux | the four addressed outputs load the nibble; all other outputs clear |
| 1 | 1 | clear | everything clears |

While the host is held in reset, both controls sit high, so the register clears before any write reaches it. Output bit 14 is an active-high supply enable for the critical relays. It is also brought out separately as `relay_en`, so the all-zero state keeps those relays switched off.

Top module: `mlatch_top`

## Requirements
- R1: While `rst` is high at a rising edge, all 32 outputs become 0 after that edge, whatever `clr_req` and `wr_block` are.
- R2: With `clr_req`=0 and `wr_block`=0 (write mode), the four addressed outputs load the data nibble at the edge, and the other 28 outputs keep their values.
- R3: With `clr_req`=0 and `wr_block`=1 (storage mode), all 32 outputs keep their values at the edge, whatever the address and data are.
- R4: With `clr_req`=1 and `wr_block`=0 (demux mode), the four addressed outputs load the nibble at the edge, and the other 28 outputs become 0.
- R5: With `clr_req`=1 and `wr_block`=1 (clear mode), all 32 outputs become 0 at the edge, whatever the address and data are.
- R6: For address a (0 to 7), data bit k (0 to 3) goes to output bit `8*k + a`. Address 0 with data bit 0 reaches output 0; address 7 with data bit 3 reaches output 31.
- R7: `relay_en` always equals output bit 14, which is loaded by address 6, data bit 1. After any edge in clear mode, `relay_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all outputs change on its rising edge |
| rst | input | 1 | Synchronous active-high reset; clears all outputs |
| addr | input | 3 | Bit position selected within every byte lane |
| data | input | 4 | Nibble; bit k goes to lane k |
| clr_req | input | 1 | Clear request; with `wr_block` it selects the mode |
| wr_block | input | 1 | Write block; with `clr_req` it selects the mode |
| q | output | 32 | Registered control outputs |
| relay_en | output | 1 | Relay supply enable, a copy of `q[14]` |

## Verification
The bench targets the two modes that are easy to confuse. Demux mode must clear the unaddressed bits while loading the addressed ones; a design that treated it as write mode would leave stale ones on outputs. Storage mode must ignore address and data that are changing; a design that decoded only `clr_req` would corrupt outputs there. The address ends 0 and 7 and the relay bit 14 are written directly, which catches a lane stride or bit order that has been swapped. Random streams that mix all four modes are compared against a behavioural model on every edge.

// File: rtl/mlatch_pkg.sv
package mlatch_pkg;
  typedef enum logic [1:0] {
    MODE_WRITE = 2'b00,
    MODE_HOLD  = 2'b01,
    MODE_DEMUX = 2'b10,
    MODE_CLEAR = 2'b11
  } mode_t;
endpackage

// File: rtl/mlatch_mode_dec.sv
module mlatch_mode_dec
  import mlatch_pkg::*;
(
  input  logic  clr_req,
  input  logic  wr_block,
  output mode_t mode
);
  always_comb begin
    unique case ({clr_req, wr_block})
      2'b00:   mode = MODE_WRITE;
      2'b01:   mode = MODE_HOLD;
      2'b10:   mode = MODE_DEMUX;
      default: mode = MODE_CLEAR;
    endcase
  end
endmodule

// File: rtl/mlatch_lane.sv
module mlatch_lane
  import mlatch_pkg::*;
#(
  parameter int ADDR_W = 3,
  localparam int LANE_W = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  mode_t             mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              din,
  output logic [LANE_W-1:0] bits
);
  logic [LANE_W-1:0] sel;
  logic [LANE_W-1:0] nxt;

  always_comb begin
    sel = '0;
    sel[addr] = 1'b1;
  end

  always_comb begin
    unique case (mode)
      MODE_WRITE: nxt = (bits & ~sel) | (sel & {LANE_W{din}});
      MODE_HOLD:  nxt = bits;
      MODE_DEMUX: nxt = sel & {LANE_W{din}};
      default:    nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bits <= '0;
    else     bits <= nxt;
  end
endmodule

// File: rtl/mlatch_top.sv
module mlatch_top
  import mlatch_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int LANES     = 4,
  parameter int RELAY_BIT = 14,
  localparam int LANE_W = 1 << ADDR_W,
  localparam int Q_W    = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  data,
  input  logic              clr_req,
  input  logic              wr_block,
  output logic [Q_W-1:0]    q,
  output logic              relay_en
);
  mode_t mode;

  mlatch_mode_dec u_dec (
    .clr_req (clr_req),
    .wr_block(wr_block),
    .mode    (mode)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    mlatch_lane #(.ADDR_W(ADDR_W)) u_lane (
      .clk (clk),
      .rst (rst),
      .mode(mode),
      .addr(addr),
      .din (data[k]),
      .bits(q[k*LANE_W +: LANE_W])
    );
  end

  assign relay_en = q[RELAY_BIT];
endmodule

// File: rtl/mlatch_chk.sv
module mlatch_chk #(
  parameter int ADDR_W    = 3,
  parameter int LANES     = 4,
  parameter int RELAY_BIT = 14,
  localparam int LANE_W = 1 << ADDR_W,
  localparam int Q_W    = LANES * LANE_W
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic [LANES-1:0]  data,
  input logic              clr_req,
  input logic              wr_block,
  input logic [Q_W-1:0]    q,
  input logic              relay_en
);
  function automatic logic [Q_W-1:0] pos_mask(input logic [ADDR_W-1:0] a);
    logic [Q_W-1:0] m;
    m = '0;
    for (int k = 0; k < LANES; k++) m[k*LANE_W + int'(a)] = 1'b1;
    return m;
  endfunction

  function automatic logic [Q_W-1:0] spread(input logic [ADDR_W-1:0] a,
                                            input logic [LANES-1:0] d);
    logic [Q_W-1:0] m;
    m = '0;
    for (int k = 0; k < LANES; k++) m[k*LANE_W + int'(a)] = d[k];
    return m;
  endfunction

  logic prev_rst;
  always_ff @(posedge clk) prev_rst <= rst;

  // R1: a reset edge leaves every output at zero
  always @(negedge clk) begin
    if (prev_rst === 1'b1) p_reset_zero_r1: assert (q == '0);
  end

  p_write_keep_r2: assert property (@(posedge clk) disable iff (rst)
    (!clr_req && !wr_block) |=>
      (((q ^ $past(q)) & ~pos_mask($past(addr))) == '0) &&
      ((q & pos_mask($past(addr))) == spread($past(addr), $past(data))));

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!clr_req && wr_block) |=> $stable(q));

  p_demux_r4: assert property (@(posedge clk) disable iff (rst)
    (clr_req && !wr_block) |=> q == spread($past(addr), $past(data)));

  p_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (clr_req && wr_block) |=> q == '0);

  p_relay_off_r7: assert property (@(posedge clk) disable iff (rst)
    (clr_req && wr_block) |=> !relay_en);

  always @(negedge clk) begin
    p_relay_mirror_r7: assert (relay_en === q[RELAY_BIT]);
  end
endmodule

bind mlatch_top mlatch_chk #(
  .ADDR_W(ADDR_W), .LANES(LANES), .RELAY_BIT(RELAY_BIT)
) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .data(data), .clr_req(clr_req),
  .wr_block(wr_block), .q(q), .relay_en(relay_en)
);

// File: tb/mlatch_tb.sv
`timescale 1ns/1ps
module mlatch_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  addr = '0;
  logic [3:0]  data = '0;
  logic        clr_req = 1'b1;
  logic        wr_block = 1'b1;
  logic [31:0] q;
  logic        relay_en;

  int checks = 0;
  int errors = 0;
  logic [31:0] model = '0;
  bit done = 0;

  always #4 clk = ~clk;

  mlatch_top dut_i (
    .clk(clk), .rst(rst), .addr(addr), .data(data), .clr_req(clr_req),
    .wr_block(wr_block), .q(q), .relay_en(relay_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive at negedge, apply behavioural model at posedge, compare 1 ns after.
  task automatic step(input bit r, input bit c, input bit w, input int a, input int d);
    string tag;
    @(negedge clk);
    rst = r; clr_req = c; wr_block = w; addr = 3'(a); data = 4'(d);
    @(posedge clk);
    if (r) begin
      model = '0; tag = "R1";
    end else if (!c && !w) begin
      for (int k = 0; k < 4; k++) model[a + 8*k] = d[k];
      tag = "R2";
    end else if (!c && w) begin
      tag = "R3";
    end else if (c && !w) begin
      model = '0;
      for (int k = 0; k < 4; k++) model[a + 8*k] = d[k];
      tag = "R4";
    end else begin
      model = '0; tag = "R5";
    end
    #1;
    check(tag, q, model);
    check("R7 mirror", {31'd0, relay_en}, {31'd0, model[14]});
    if (c && w && !r) check("R7 off after clear", {31'd0, relay_en}, 32'd0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: power-on with both controls high and reset asserted
    step(1, 1, 1, 0, 0);
    step(1, 0, 0, 5, 15);
    check("R1 reset state", q, 32'd0);
    // R6: boundary addresses and lane order
    step(0, 0, 0, 0, 1);
    check("R6 addr0 bit0", q, 32'h0000_0001);
    step(0, 0, 0, 7, 8);
    check("R6 addr7 bit3", q, 32'h8000_0001);
    step(0, 0, 0, 3, 4'b0110);
    check("R6 lanes1,2", q, 32'h8008_0801);
    // R7: relay bit via address 6 lane 1
    step(0, 0, 0, 6, 4'b0010);
    check("R7 relay set", {31'd0, relay_en}, 32'd1);
    // R3: storage ignores changing inputs
    for (int i = 0; i < 8; i++) step(0, 0, 1, i, 15 - i);
    check("R3 held", q, 32'h8008_4801);
    // R2: write zero clears only addressed bits
    step(0, 0, 0, 3, 0);
    check("R2 partial clear", q, 32'h8000_4001);
    // R4: demux loads addressed, clears rest
    step(0, 1, 0, 2, 4'b1001);
    check("R4 demux", q, 32'h0400_0004);
    // R5: clear mode
    step(0, 0, 0, 6, 4'b1111);
    step(0, 1, 1, 6, 4'b1111);
    check("R5 clear", q, 32'd0);
    // Random mixed stream
    for (int i = 0; i < 2000; i++)
      step(($urandom % 50) == 0, $urandom % 2, $urandom % 2, $urandom % 8, $urandom % 16);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule